// File: doc/BRIEF.md
# Dual-Channel UART Host Register Front End

This block is the host-facing register front end of a two-channel UART. A host drives an 8-bit data bus, a 3-bit register offset, an active-low chip select, a channel select line and active-low read and write strobes. Each access is steered to one of two identical register banks. A bank holds a 16-bit baud divisor as two bytes, a line control register, a scratch byte and an alternate function register. The transmit and receive engines, the FIFOs and the baud generator live elsewhere. At the unused data and interrupt-enable locations this block returns zero.

Reads are combinational from the bus inputs and need no clock. Writes pass through a synchronizer into the internal clock domain. Each write is committed once, after the write strobe is released. When both divisor bytes of a channel are zero, the two divisor locations return a fixed device identifier and a revision code instead of the stored bytes. Each channel also owns one multifunction output pin. A two-bit field of that channel's alternate function register selects what drives the pin.

Top module: `duart_host_regs`

## Requirements
- R1: An access takes effect only while `cs_n` is 0. A write strobe with `cs_n` at 1 changes no register. `rdata` is 0x00 whenever `cs_n` or `rd_n` is 1.
- R2: `chan_sel` = 0 addresses bank A and `chan_sel` = 1 addresses bank B. A write to one bank never changes the other.
- R3: Offset 3 is the line control register and offset 7 is the scratch register. Both can be written and read back at any time. Offsets 4, 5 and 6 read 0x00.
- R4: While line control bit 7 is 1, offset 0 is the divisor low byte and offset 1 is the divisor high byte. While that bit is 0, offsets 0 and 1 read 0x00 and writes to them leave the divisor unchanged.
- R5: While line control bit 7 is 1 and both divisor bytes of the addressed channel are 0x00, offset 1 reads the device identifier 0x12 and offset 0 reads the revision code 0x01.
- R6: While line control bit 7 is 1 and either divisor byte is nonzero, offsets 0 and 1 read the stored divisor bytes.
- R7: The alternate function register is at offset 2 only while the line control register equals 0xBF. At any other line control value, offset 2 reads 0x00 and ignores writes.
- R8: `mf_n[c]` follows bits [2:1] of channel c's alternate function register. 00 selects `gpo_n[c]`, 01 selects `baud_n[c]`, 10 selects `rxrdy_n[c]`, and 11 drives a constant 1.
- R9: A write stores the offset, channel and data present while `wr_n` was 0. The update appears after `wr_n` rises: it is absent one clock later and present by the fourth clock edge. Each strobe causes exactly one update.
- R10: An active-high `rst` clears every register of both channels to 0x00. The multifunction pins then follow `gpo_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock used to commit writes |
| rst | input | 1 | Asynchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| chan_sel | input | 1 | Channel select: 0 = A, 1 = B |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 3 | Register offset within a channel |
| wdata | input | 8 | Write data from the host |
| rdata | output | 8 | Read data to the host, 0 when no read is in progress |
| gpo_n | input | 2 | Per-channel general-purpose output source |
| baud_n | input | 2 | Per-channel baud clock output source |
| rxrdy_n | input | 2 | Per-channel receive-ready source |
| mf_n | output | 2 | Per-channel multifunction output pin |

## Verification
Divisor readback is swept over sixteen byte patterns in each byte position and on both channels. This separates identifier substitution, which happens only when both bytes are zero, from plain readback. The zero case in each byte on its own proves that the test looks at both bytes. All four selector encodings of the multifunction pin are combined with all eight input patterns on each channel, so every source is seen at both levels and a swapped source shows up. Different values written into the two banks, together with writes under an inactive chip select, a clear access bit and a line control value other than the key, show isolation and ignored writes. A write whose bus values are replaced as the strobe rises shows which values are captured and when the update lands.

// File: rtl/duart_host_regs.sv
module duart_host_regs #(
  parameter logic [7:0] DEV_ID  = 8'h12,
  parameter logic [7:0] REV_ID  = 8'h01,
  parameter logic [7:0] AFR_KEY = 8'hBF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       chan_sel,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [1:0] gpo_n,
  input  logic [1:0] baud_n,
  input  logic [1:0] rxrdy_n,
  output logic [1:0] mf_n
);
  localparam int NCH = 2;

  logic [2:0] wsy;
  logic       cap_v, cap_ch;
  logic [2:0] cap_a;
  logic [7:0] cap_d;
  logic       commit;

  logic [7:0] dll_q [NCH];
  logic [7:0] dlm_q [NCH];
  logic [7:0] lcr_q [NCH];
  logic [7:0] spr_q [NCH];
  logic [7:0] afr_q [NCH];

  always_ff @(posedge clk or posedge rst)
    if (rst) wsy <= '1;
    else     wsy <= {wsy[1:0], wr_n};

  assign commit = wsy[1] & ~wsy[2];

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      cap_v  <= 1'b0;
      cap_ch <= 1'b0;
      cap_a  <= '0;
      cap_d  <= '0;
    end else if (!wsy[0] && !wr_n) begin
      cap_v  <= !cs_n;
      cap_ch <= chan_sel;
      cap_a  <= addr;
      cap_d  <= wdata;
    end

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        dll_q[c] <= '0;
        dlm_q[c] <= '0;
        lcr_q[c] <= '0;
        spr_q[c] <= '0;
        afr_q[c] <= '0;
      end
    end else if (commit && cap_v) begin
      case (cap_a)
        3'd0: if (lcr_q[cap_ch][7])        dll_q[cap_ch] <= cap_d;
        3'd1: if (lcr_q[cap_ch][7])        dlm_q[cap_ch] <= cap_d;
        3'd2: if (lcr_q[cap_ch] == AFR_KEY) afr_q[cap_ch] <= cap_d;
        3'd3: lcr_q[cap_ch] <= cap_d;
        3'd7: spr_q[cap_ch] <= cap_d;
        default: ;
      endcase
    end

  logic [7:0] rsel;
  logic       dl_zero;
  assign dl_zero = (dll_q[chan_sel] == 8'h00) && (dlm_q[chan_sel] == 8'h00);

  always_comb begin
    rsel = 8'h00;
    case (addr)
      3'd0: if (lcr_q[chan_sel][7]) rsel = dl_zero ? REV_ID : dll_q[chan_sel];
      3'd1: if (lcr_q[chan_sel][7]) rsel = dl_zero ? DEV_ID : dlm_q[chan_sel];
      3'd2: if (lcr_q[chan_sel] == AFR_KEY) rsel = afr_q[chan_sel];
      3'd3: rsel = lcr_q[chan_sel];
      3'd7: rsel = spr_q[chan_sel];
      default: rsel = 8'h00;
    endcase
  end

  assign rdata = (!cs_n && !rd_n) ? rsel : 8'h00;

  for (genvar c = 0; c < NCH; c++) begin : g_mf
    always_comb
      case (afr_q[c][2:1])
        2'b00:   mf_n[c] = gpo_n[c];
        2'b01:   mf_n[c] = baud_n[c];
        2'b10:   mf_n[c] = rxrdy_n[c];
        default: mf_n[c] = 1'b1;
      endcase
  end
endmodule

module duart_host_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       rd_n,
  input logic       chan_sel,
  input logic [2:0] addr,
  input logic [7:0] rdata,
  input logic [1:0] mf_n,
  input logic       commit,
  input logic [7:0] dll_a,
  input logic [7:0] dlm_a,
  input logic [7:0] lcr_a,
  input logic [7:0] afr_a
);
  p_idle_bus_r1: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |-> rdata == 8'h00);

  p_id_read_r5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && !chan_sel && addr == 3'd1 && lcr_a[7] && dll_a == 8'h00 && dlm_a == 8'h00)
      |-> rdata == 8'h12);

  p_mf_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (afr_a[2:1] == 2'b11) |-> mf_n[0]);

  p_single_update_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(dll_a) |-> $past(commit));

  p_afr_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(afr_a) |-> $past(lcr_a) == 8'hBF);

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (lcr_a == 8'h00 && afr_a == 8'h00 && dll_a == 8'h00));
endmodule

bind duart_host_regs duart_host_regs_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .chan_sel(chan_sel),
  .addr(addr), .rdata(rdata), .mf_n(mf_n), .commit(commit),
  .dll_a(dll_q[0]), .dlm_a(dlm_q[0]), .lcr_a(lcr_q[0]), .afr_a(afr_q[0])
);

// File: tb/duart_host_regs_tb.sv
module duart_host_regs_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic       cs_n = 1, chan_sel = 0, rd_n = 1, wr_n = 1;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [1:0] gpo_n = 0, baud_n = 0, rxrdy_n = 0;
  logic [1:0] mf_n;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [7:0] m_dll [2], m_dlm [2], m_lcr [2], m_spr [2], m_afr [2];

  always #2 clk = ~clk;

  duart_host_regs u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .chan_sel(chan_sel), .rd_n(rd_n),
    .wr_n(wr_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .gpo_n(gpo_n), .baud_n(baud_n), .rxrdy_n(rxrdy_n), .mf_n(mf_n)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      m_dll[c] = 0; m_dlm[c] = 0; m_lcr[c] = 0; m_spr[c] = 0; m_afr[c] = 0;
    end
  endtask

  function automatic logic [7:0] exp_rd(int c, int a);
    logic z;
    z = (m_dll[c] == 0) && (m_dlm[c] == 0);
    case (a)
      0: return m_lcr[c][7] ? (z ? 8'h01 : m_dll[c]) : 8'h00;
      1: return m_lcr[c][7] ? (z ? 8'h12 : m_dlm[c]) : 8'h00;
      2: return (m_lcr[c] == 8'hBF) ? m_afr[c] : 8'h00;
      3: return m_lcr[c];
      7: return m_spr[c];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_mf(int c);
    case (m_afr[c][2:1])
      2'b00: return gpo_n[c];
      2'b01: return baud_n[c];
      2'b10: return rxrdy_n[c];
      default: return 1'b1;
    endcase
  endfunction

  task automatic wr(int c, int a, logic [7:0] d, logic csn = 1'b0);
    @(negedge clk);
    cs_n = csn; chan_sel = c[0]; addr = a[2:0]; wdata = d; wr_n = 0;
    repeat (3) @(negedge clk);
    wr_n = 1; wdata = ~d; addr = ~a[2:0]; chan_sel = ~c[0];
    repeat (5) @(negedge clk);
    cs_n = 1;
    if (!csn) begin
      case (a)
        0: if (m_lcr[c][7]) m_dll[c] = d;
        1: if (m_lcr[c][7]) m_dlm[c] = d;
        2: if (m_lcr[c] == 8'hBF) m_afr[c] = d;
        3: m_lcr[c] = d;
        7: m_spr[c] = d;
        default: ;
      endcase
    end
  endtask

  task automatic rd(int c, int a, output logic [7:0] v);
    @(negedge clk);
    cs_n = 0; chan_sel = c[0]; addr = a[2:0]; rd_n = 0;
    #1 v = rdata;
    rd_n = 1; cs_n = 1;
  endtask

  task automatic rd_chk(string req, int c, int a);
    logic [7:0] v;
    rd(c, a, v);
    chk(req, v, exp_rd(c, a));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);

    // R10 reset defaults, R3/R4/R7 idle offsets
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 8; a++) rd_chk("R10 reset read", c, a);
    gpo_n = 2'b10; #1;
    chk("R10 mf follows gpo", {6'd0, mf_n}, 8'h02);

    // R1 idle bus
    @(negedge clk); cs_n = 0; rd_n = 1; addr = 3; #1;
    chk("R1 rdata idle when rd_n high", rdata, 8'h00);
    cs_n = 1;

    // R4 divisor hidden while access bit clear
    wr(0, 0, 8'h55);
    rd_chk("R4 dll hidden", 0, 0);

    // R5 identification on both channels
    for (int c = 0; c < 2; c++) begin
      wr(c, 3, 8'h80);
      rd_chk("R5 revision", c, 0);
      rd_chk("R5 identifier", c, 1);
      rd(c, 1, v); chk("R5 identifier value", v, 8'h12);
      rd(c, 0, v); chk("R5 revision value", v, 8'h01);
    end

    // R6 sweep of divisor patterns, both bytes and channels
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 16; i++) begin
        wr(c, 0, 8'(i * 17)); wr(c, 1, 8'h00);
        rd_chk("R6 dll sweep", c, 0); rd_chk("R6 dlm sweep", c, 1);
        wr(c, 0, 8'h00); wr(c, 1, 8'(i * 17));
        rd_chk("R6 dll sweep z", c, 0); rd_chk("R6 dlm sweep z", c, 1);
      end
    rd_chk("R2 other bank divisor", 0, 0);

    // R2 bank isolation, R3 scratch and line control
    wr(0, 7, 8'hA5); wr(1, 7, 8'h5A);
    wr(0, 0, 8'h3C); wr(1, 0, 8'hC3);
    for (int c = 0; c < 2; c++) begin
      rd_chk("R2 scratch isolated", c, 7);
      rd_chk("R2 dll isolated", c, 0);
      rd_chk("R3 lcr", c, 3);
      for (int a = 4; a < 7; a++) rd_chk("R3 unused offset", c, a);
    end

    // R1 write with chip select inactive
    wr(0, 7, 8'hFF, 1'b1);
    rd_chk("R1 write ignored cs high", 0, 7);

    // R4 write ignored while bit clear
    wr(1, 3, 8'h03); wr(1, 0, 8'h77); wr(1, 3, 8'h80);
    rd_chk("R4 dll unchanged", 1, 0);

    // R7 AFR gating
    wr(0, 3, 8'h83); wr(0, 2, 8'h06);
    rd_chk("R7 offset2 zero", 0, 2);
    chk("R7 afr untouched", {7'd0, mf_n[0]}, {7'd0, exp_mf(0)});

    // R8 all encodings x input patterns x channels
    for (int c = 0; c < 2; c++) begin
      wr(c, 3, 8'hBF);
      for (int s = 0; s < 4; s++) begin
        wr(c, 2, 8'(s << 1));
        rd_chk("R7 afr readback", c, 2);
        for (int p = 0; p < 8; p++) begin
          gpo_n = {p[0], p[0]}; baud_n = {p[1], p[1]}; rxrdy_n = {p[2], p[2]};
          #1;
          chk("R8 mf select", {7'd0, mf_n[c]}, {7'd0, exp_mf(c)});
        end
      end
    end
    chk("R2 mf other channel", {7'd0, mf_n[0]}, {7'd0, exp_mf(0)});

    // R9 write timing and captured values
    @(negedge clk);
    cs_n = 0; chan_sel = 0; addr = 7; wdata = 8'h96; wr_n = 0;
    repeat (3) @(negedge clk);
    wr_n = 1; wdata = 8'h00; addr = 3; chan_sel = 1;
    @(negedge clk);
    cs_n = 1;
    rd(0, 7, v); chk("R9 not yet committed", v, m_spr[0]);
    repeat (3) @(negedge clk);
    m_spr[0] = 8'h96;
    rd_chk("R9 committed captured value", 0, 7);
    rd_chk("R9 other lcr unchanged", 1, 3);

    // R10 reset mid-run
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    model_clear();
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 8; a++) rd_chk("R10 reset restores", c, a);
    gpo_n = 2'b01; #1;
    chk("R10 mf after reset", {6'd0, mf_n}, 8'h01);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule